// File: doc/BRIEF.md
# Dual Watchpoint and Breakpoint Unit

This block is the hardware comparator behind on-chip debug of a processor core. It holds two match units. Each unit can be programmed with an address, a data value and a small control pattern, every one of them paired with a mask. Each unit runs in one of two modes.

- As a breakpoint, a unit watches the execute stage. It stops the core when an instruction at the chosen address is about to execute.
- As a watchpoint, a unit watches the memory bus. It stops the core when a data transfer with a chosen address, value and kind completes.

An external debug request input also stops the core. The halt is sticky. While it lasts, the core's memory cycle type is forced to "internal", and a cause vector records what started it. A write to the exit location releases it.

The configuration port is a plain register write strobe. It stands in for the serial test-access path, which is outside this block. The bus and execute-stage inputs are passive taps on the core: each carries a valid flag but no ready, because the block only observes and never holds a transfer back. A configuration write is accepted on every cycle in which `cfg_we` is high, so there is no back-pressure anywhere.

Top module: `dual_wbp_unit`

## Requirements
- R1: After reset, `halt_o` is low and `dbg_cause` is 0. Both units are disabled with all value and mask registers at zero. `mem_cyc` equals `core_cyc`.
- R2: A unit whose control register has enable (bit 0) set and mode (bit 1) clear is a breakpoint. The configuration map is: `cfg_addr[3]` selects the unit; offsets 0, 1, 2, 3 and 4 hold address value, address mask, data value, data mask and control. A breakpoint raises `halt_o` in the same cycle as `ex_valid` with an `ex_addr` that matches. From the next cycle the halt is held and `dbg_cause` bit u is set, where u is the unit number.
- R3: A unit with enable and mode (bit 1) both set is a watchpoint. It matches on a cycle with `bus_valid` high and `bus_fetch` low whose address, data and `bus_ctl` ({size[1:0], write}) all match. `halt_o` rises in the cycle after that transfer. Control bits [4:2] hold the expected `bus_ctl` and bits [7:5] hold its mask.
- R4: A mask bit of 1 makes the corresponding bit of its field a don't-care in the comparison.
- R5: A disabled unit never matches. A breakpoint unit ignores bus transfers. A watchpoint unit ignores executed instructions and instruction fetch cycles.
- R6: `dbg_req` high while not halted raises `halt_o` from the next cycle and sets `dbg_cause[2]`.
- R7: Once entered, the halt stays until a write to `cfg_addr` 4'hF. In the cycle after that write, `halt_o` is low and `dbg_cause` is 0. The exit write does nothing while the block is not halted.
- R8: `dbg_cause` is captured only on entry. It records every source that fired in the entry cycle. Matches and requests while halted leave it unchanged.
- R9: While `halt_o` is high, `mem_cyc` is 2'b00 (internal cycle). Otherwise `mem_cyc` equals `core_cyc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Unit select (bit 3) and register offset; 4'hF is debug exit |
| cfg_wdata | input | 32 | Configuration write data |
| ex_valid | input | 1 | An instruction is about to execute this cycle |
| ex_addr | input | 32 | Address of the executing instruction |
| bus_valid | input | 1 | A bus transfer completes this cycle |
| bus_fetch | input | 1 | The transfer is an instruction fetch |
| bus_addr | input | 32 | Transfer address |
| bus_data | input | 32 | Transfer data |
| bus_ctl | input | 3 | {size[1:0], write} of the transfer |
| core_cyc | input | 2 | Cycle type requested by the core |
| dbg_req | input | 1 | External debug request |
| halt_o | output | 1 | Core halt / debug state |
| dbg_cause | output | 3 | Entry cause: bit 0 unit 0, bit 1 unit 1, bit 2 external |
| mem_cyc | output | 2 | Cycle type presented to memory |

## Verification
The hardest situation to reach is an entry cycle in which several sources fire at once. The bench sets one up by arming a breakpoint and raising the external request in the same cycle, so the cause must show both bits. A second hard case is a match that arrives after the halt has already begun; the bench keeps stepping matching fetches and requests while halted to show the cause does not move. Watchpoint near-misses are driven as well: a read where a write is expected, a fetch at the watched address, and a disabled unit, each followed by idle cycles so that any late halt would be seen.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef enum logic [1:0] {
    CYC_INTERNAL = 2'b00,
    CYC_NONSEQ   = 2'b01,
    CYC_SEQ      = 2'b10,
    CYC_COPRO    = 2'b11
  } cyc_e;

  localparam int CTL_W = 3;

  localparam logic [2:0] OFF_AVAL  = 3'd0;
  localparam logic [2:0] OFF_AMASK = 3'd1;
  localparam logic [2:0] OFF_DVAL  = 3'd2;
  localparam logic [2:0] OFF_DMASK = 3'd3;
  localparam logic [2:0] OFF_CTL   = 3'd4;

  typedef struct packed {
    logic [CTL_W-1:0] msk;
    logic [CTL_W-1:0] val;
    logic             wp_mode;
    logic             en;
  } unit_ctl_t;
endpackage

// File: rtl/wbp_mask_cmp.sv
module wbp_mask_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] probe,
  input  logic [W-1:0] ref_val,
  input  logic [W-1:0] care_n,
  output logic         hit
);
  logic [W-1:0] diff;
  always_comb begin
    diff = (probe ^ ref_val) & ~care_n;
    hit  = (diff == '0);
  end
endmodule

// File: rtl/wbp_match_unit.sv
module wbp_match_unit
  import wbp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ex_valid,
  input  logic [ADDR_W-1:0] ex_addr,
  input  logic              bus_valid,
  input  logic              bus_fetch,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [CTL_W-1:0]  bus_ctl,
  output logic              bp_hit,
  output logic              wp_hit
);
  localparam int UCTL_W = $bits(unit_ctl_t);

  logic [ADDR_W-1:0] aval_q, amask_q;
  logic [DATA_W-1:0] dval_q, dmask_q;
  unit_ctl_t         ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aval_q  <= '0;
      amask_q <= '0;
      dval_q  <= '0;
      dmask_q <= '0;
      ctl_q   <= '0;
    end else if (wr_en) begin
      case (wr_off)
        OFF_AVAL:  aval_q  <= wr_data[ADDR_W-1:0];
        OFF_AMASK: amask_q <= wr_data[ADDR_W-1:0];
        OFF_DVAL:  dval_q  <= wr_data;
        OFF_DMASK: dmask_q <= wr_data;
        OFF_CTL:   ctl_q   <= unit_ctl_t'(wr_data[UCTL_W-1:0]);
        default: ;
      endcase
    end
  end

  logic ex_addr_ok, bus_addr_ok, bus_data_ok, bus_ctl_ok;

  wbp_mask_cmp #(.W(ADDR_W)) u_cmp_exa (
    .probe(ex_addr), .ref_val(aval_q), .care_n(amask_q), .hit(ex_addr_ok));
  wbp_mask_cmp #(.W(ADDR_W)) u_cmp_bsa (
    .probe(bus_addr), .ref_val(aval_q), .care_n(amask_q), .hit(bus_addr_ok));
  wbp_mask_cmp #(.W(DATA_W)) u_cmp_bsd (
    .probe(bus_data), .ref_val(dval_q), .care_n(dmask_q), .hit(bus_data_ok));
  wbp_mask_cmp #(.W(CTL_W)) u_cmp_ctl (
    .probe(bus_ctl), .ref_val(ctl_q.val), .care_n(ctl_q.msk), .hit(bus_ctl_ok));

  always_comb begin
    bp_hit = ctl_q.en && !ctl_q.wp_mode && ex_valid && ex_addr_ok;
    wp_hit = ctl_q.en && ctl_q.wp_mode && bus_valid && !bus_fetch
             && bus_addr_ok && bus_data_ok && bus_ctl_ok;
  end
endmodule

// File: rtl/wbp_halt_ctl.sv
module wbp_halt_ctl #(
  parameter int NUM_UNITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] unit_hit,
  input  logic                 ext_req,
  input  logic                 exit_wr,
  output logic                 dbg_q,
  output logic [NUM_UNITS:0]   cause_q
);
  logic [NUM_UNITS:0] src;
  logic               entry;

  always_comb begin
    src   = {ext_req, unit_hit};
    entry = !dbg_q && (src != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q   <= 1'b0;
      cause_q <= '0;
    end else if (dbg_q) begin
      if (exit_wr) begin
        dbg_q   <= 1'b0;
        cause_q <= '0;
      end
    end else if (entry) begin
      dbg_q   <= 1'b1;
      cause_q <= src;
    end
  end
endmodule

// File: rtl/dual_wbp_unit.sv
module dual_wbp_unit
  import wbp_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [$clog2(NUM_UNITS)+2:0]   cfg_addr,
  input  logic [DATA_W-1:0]              cfg_wdata,
  input  logic                           ex_valid,
  input  logic [ADDR_W-1:0]              ex_addr,
  input  logic                           bus_valid,
  input  logic                           bus_fetch,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_data,
  input  logic [CTL_W-1:0]               bus_ctl,
  input  logic [1:0]                     core_cyc,
  input  logic                           dbg_req,
  output logic                           halt_o,
  output logic [NUM_UNITS:0]             dbg_cause,
  output logic [1:0]                     mem_cyc
);
  localparam int CFG_AW = $clog2(NUM_UNITS) + 3;
  localparam int SEL_W  = CFG_AW - 3;
  localparam logic [CFG_AW-1:0] EXIT_ADDR = '1;

  logic                 exit_wr;
  logic [NUM_UNITS-1:0] bp_vec, wp_vec, hit_vec;
  logic                 dbg_q;

  assign exit_wr = cfg_we && (cfg_addr == EXIT_ADDR);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic sel;
    assign sel = cfg_we && !exit_wr && (cfg_addr[CFG_AW-1:3] == SEL_W'(u));
    wbp_match_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
      .clk(clk), .rst_n(rst_n),
      .wr_en(sel), .wr_off(cfg_addr[2:0]), .wr_data(cfg_wdata),
      .ex_valid(ex_valid), .ex_addr(ex_addr),
      .bus_valid(bus_valid), .bus_fetch(bus_fetch),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctl(bus_ctl),
      .bp_hit(bp_vec[u]), .wp_hit(wp_vec[u]));
    assign hit_vec[u] = bp_vec[u] | wp_vec[u];
  end

  wbp_halt_ctl #(.NUM_UNITS(NUM_UNITS)) u_halt (
    .clk(clk), .rst_n(rst_n),
    .unit_hit(hit_vec), .ext_req(dbg_req), .exit_wr(exit_wr),
    .dbg_q(dbg_q), .cause_q(dbg_cause));

  always_comb begin
    halt_o  = dbg_q || (bp_vec != '0);
    mem_cyc = halt_o ? CYC_INTERNAL : core_cyc;
  end
endmodule

// File: rtl/wbp_chk.sv
module wbp_chk #(
  parameter int NUM_UNITS = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_we,
  input logic [$clog2(NUM_UNITS)+2:0] cfg_addr,
  input logic                         dbg_req,
  input logic [1:0]                   core_cyc,
  input logic                         halt_o,
  input logic [NUM_UNITS:0]           dbg_cause,
  input logic [1:0]                   mem_cyc
);
  logic exit_w;
  assign exit_w = cfg_we && (cfg_addr == '1);

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !exit_w) |=> halt_o);
  assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((dbg_cause != '0) && exit_w) |=> (dbg_cause == '0));
  assert_ext_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !halt_o) |=> (halt_o && dbg_cause[NUM_UNITS]));
  assert_cause_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dbg_cause != '0) && !exit_w) |=> $stable(dbg_cause));
  assert_cause_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_cause != '0) |-> halt_o);
  assert_cyc_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (mem_cyc == 2'b00));
  assert_cyc_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_o |-> (mem_cyc == core_cyc));
endmodule

bind dual_wbp_unit wbp_chk #(.NUM_UNITS(NUM_UNITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .dbg_req(dbg_req), .core_cyc(core_cyc), .halt_o(halt_o),
  .dbg_cause(dbg_cause), .mem_cyc(mem_cyc));

// File: tb/dual_wbp_unit_tb_top.sv
module dual_wbp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ex_valid = 1'b0;
  logic [31:0] ex_addr = '0;
  logic        bus_valid = 1'b0, bus_fetch = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic [2:0]  bus_ctl = '0;
  logic [1:0]  core_cyc = '0;
  logic        dbg_req = 1'b0;
  logic        halt_o;
  logic [2:0]  dbg_cause;
  logic [1:0]  mem_cyc;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  dual_wbp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ex_valid(ex_valid), .ex_addr(ex_addr),
    .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_ctl(bus_ctl), .core_cyc(core_cyc),
    .dbg_req(dbg_req), .halt_o(halt_o), .dbg_cause(dbg_cause),
    .mem_cyc(mem_cyc));

  // Reference model state
  logic [31:0] m_av[2], m_am[2], m_dv[2], m_dm[2];
  logic [7:0]  m_ct[2];
  bit          m_dbg = 1'b0;
  logic [2:0]  m_cause = '0;

  function automatic bit mhit(logic [31:0] a, logic [31:0] v, logic [31:0] m);
    return ((a ^ v) & ~m) == 32'd0;
  endfunction

  function automatic bit m_bp(int u);
    return m_ct[u][0] && !m_ct[u][1] && ex_valid && mhit(ex_addr, m_av[u], m_am[u]);
  endfunction

  function automatic bit m_wp(int u);
    return m_ct[u][0] && m_ct[u][1] && bus_valid && !bus_fetch
      && mhit(bus_addr, m_av[u], m_am[u]) && mhit(bus_data, m_dv[u], m_dm[u])
      && (((bus_ctl ^ m_ct[u][4:2]) & ~m_ct[u][7:5]) == 3'd0);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    bit         exp_halt;
    logic [2:0] hits;
    bit         exit_w;
    #1;
    exp_halt = m_dbg || m_bp(0) || m_bp(1);
    check({tag, " halt"}, 32'(halt_o), 32'(exp_halt));
    check({tag, " cause"}, 32'(dbg_cause), 32'(m_cause));
    check({tag, " cyc R9"}, 32'(mem_cyc), exp_halt ? 32'd0 : 32'(core_cyc));
    hits   = {dbg_req, m_bp(1) | m_wp(1), m_bp(0) | m_wp(0)};
    exit_w = cfg_we && cfg_addr == 4'hF;
    @(posedge clk);
    if (m_dbg) begin
      if (exit_w) begin m_dbg = 1'b0; m_cause = '0; end
    end else if (hits != 3'd0) begin
      m_dbg = 1'b1; m_cause = hits;
    end
    if (cfg_we && !exit_w) begin
      case (cfg_addr[2:0])
        3'd0: m_av[cfg_addr[3]] = cfg_wdata;
        3'd1: m_am[cfg_addr[3]] = cfg_wdata;
        3'd2: m_dv[cfg_addr[3]] = cfg_wdata;
        3'd3: m_dm[cfg_addr[3]] = cfg_wdata;
        3'd4: m_ct[cfg_addr[3]] = cfg_wdata[7:0];
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_we = 0; ex_valid = 0; bus_valid = 0; bus_fetch = 0; dbg_req = 0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      core_cyc = 2'(i + 1);
      tick(tag);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick("R2 cfg");
    cfg_we = 0;
  endtask

  task automatic bus(logic f, logic [31:0] a, logic [31:0] d, logic [2:0] c);
    bus_valid = 1; bus_fetch = f; bus_addr = a; bus_data = d; bus_ctl = c;
    tick("R3 bus");
    bus_valid = 0; bus_fetch = 0;
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      m_av[u] = '0; m_am[u] = '0; m_dv[u] = '0; m_dm[u] = '0; m_ct[u] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 halt", 32'(halt_o), 0);
    check("R1 cause", 32'(dbg_cause), 0);
    ex_valid = 1; ex_addr = 32'h0;   // disabled units at zero must not match (R5)
    run(4, "R1");
    idle();

    // R2 breakpoint on unit 0 at 0x100
    wr(4'h0, 32'h100);
    wr(4'h4, 32'h01);
    ex_valid = 1; ex_addr = 32'h0FC; tick("R2 miss");
    ex_addr = 32'h100; #1 check("R2 same-cycle halt", 32'(halt_o), 1);
    tick("R2 hit");
    ex_valid = 0;
    check("R2 cause", 32'(dbg_cause), 32'h1);
    // R8 later sources while halted ignored
    dbg_req = 1; ex_valid = 1; run(3, "R8 halted");
    idle();
    check("R8 cause kept", 32'(dbg_cause), 32'h1);
    // R7 exit
    wr(4'hF, 0);
    check("R7 released", 32'(halt_o), 0);
    check("R7 cause clear", 32'(dbg_cause), 0);
    run(2, "R7");
    wr(4'hF, 0);   // exit while running: no effect
    run(2, "R7 idle exit");

    // R4 address mask
    wr(4'h1, 32'hFF);
    ex_valid = 1; ex_addr = 32'h2A4; tick("R4 miss");
    ex_addr = 32'h1A4; tick("R4 masked hit");
    idle();
    check("R4 halted", 32'(halt_o), 1);
    wr(4'hF, 0);
    // R5 breakpoint unit ignores bus transfers at its address
    bus(1'b0, 32'h100, 0, 3'b101);
    run(2, "R5 bp ignores bus");

    // R3 watchpoint on unit 1
    wr(4'h8, 32'h2000);
    wr(4'h9, 32'hF);
    wr(4'hA, 32'hAB);
    wr(4'hC, 32'h17);   // en, wp, ctl {size=10, write=1}, mask 0
    bus(1'b0, 32'h2004, 32'hAB, 3'b100);   // read: ctl mismatch
    run(1, "R3 read");
    bus(1'b1, 32'h2004, 32'hAB, 3'b101);   // fetch: ignored (R5)
    run(1, "R5 fetch");
    bus(1'b0, 32'h2004, 32'hAC, 3'b101);   // data mismatch
    run(1, "R3 data miss");
    ex_valid = 1; ex_addr = 32'h2004; tick("R5 wp ignores exec"); idle();
    bus(1'b0, 32'h2004, 32'hAB, 3'b101);
    check("R3 next-cycle halt", 32'(halt_o), 1);
    check("R3 cause", 32'(dbg_cause), 32'h2);
    run(2, "R3 held");
    wr(4'hF, 0);
    // R4 data mask
    wr(4'hB, 32'hF0);
    bus(1'b0, 32'h2008, 32'hCB, 3'b101);
    check("R4 data mask", 32'(dbg_cause), 32'h2);
    wr(4'hF, 0);
    // R5 disabled unit
    wr(4'hC, 32'h16);
    bus(1'b0, 32'h2004, 32'hAB, 3'b101);
    run(2, "R5 disabled");
    check("R5 no halt", 32'(halt_o), 0);

    // R6 external request
    dbg_req = 1; tick("R6 req"); dbg_req = 0;
    check("R6 cause", 32'(dbg_cause), 32'h4);
    run(2, "R6 held");
    wr(4'hF, 0);

    // R8 simultaneous sources
    ex_valid = 1; ex_addr = 32'h100; dbg_req = 1;
    tick("R8 both");
    idle();
    check("R8 both recorded", 32'(dbg_cause), 32'h5);
    run(2, "R8 held");
    wr(4'hF, 0);
    run(3, "R9 pass");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule